// File: doc/BRIEF.md
# Amplifier Chain Offset Calibration Sequencer

This block runs the foreground offset calibration of a cascade of amplifier stages, each stage having one gain bit and a small offset trim code. A single start pulse makes it short the chain input, step through every calibrated gain state and, inside each state, settle the trims one stage at a time from the input end toward the output. Each trim is found by a successive-approximation search driven by one comparator that reports the sign of the chain output. A stage trimmed later sees whatever error the earlier stages left behind and absorbs it, so the residual shrinks along the chain without any precise analog part.

Each finished set of codes is written into a small per-channel table with one word per gain state. In normal operation, a gain request picks a table word. The gain bits and the matching trim codes then reach the stage pins in the same clock cycle. A request beyond the last stored state is served by the last state. While calibration runs, gain requests are refused. When it ends, the pins return to the gain state in use before it began, now with the new codes.

Top module: `ocal_seq_top`

## Requirements
- R1: After reset, `stage_gain` is all zeros, every 3-bit trim field of `stage_trim` is midscale 3'b100, and `cal_busy`, `input_short` and `cal_done` are low; every table word also holds midscale codes.
- R2: A `cal_start` pulse seen while idle raises `cal_busy` and `input_short` on the next clock, and both stay high for the whole run. A `cal_start` seen while busy neither restarts nor extends the run.
- R3: Within a gain state, stages are trimmed in index order 0 to NSTAGE-1 and bits MSB first. A trial sets the bit under test. A high `cmp_hi` clears it again, and a low one keeps it. A stage not yet reached is held at midscale. The stored code of each stage is therefore the largest code that leaves the chain output not positive, given the final codes of the earlier stages and midscale on the later ones (0 if no code does).
- R4: Gain state i (0 to NSTATE-1) drives the thermometer pattern on `stage_gain`: bit k is 1 exactly when k < i. This holds both for calibration and for normal use.
- R5: Each trial is held for `settle_cycles`+1 clocks before the comparator is sampled on the following clock. A run keeps `cal_busy` high for NSTATE*(NSTAGE*TRIM_W*(`settle_cycles`+2)+1)+1 clocks.
- R6: `cal_done` is high for exactly one clock, the first clock after `cal_busy` falls.
- R7: In normal use, a `gain_update` loads the new gain bits and that state's stored trim codes onto the pins together on the next clock. The trim field of stage k is `stage_trim[3k+2:3k]`.
- R8: A `gain_req` above NSTATE-1 selects state NSTATE-1.
- R9: A `gain_update` seen while busy is ignored. At the end of a run, the pins return to the last gain state accepted before the run, carrying that state's new codes.
- R10: When the block is idle and no update was accepted, `stage_gain` and `stage_trim` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Pulse that starts a calibration run |
| settle_cycles | input | SETTLE_W | Extra clocks of settling allowed per trial |
| cmp_hi | input | 1 | Sign comparator at the chain output, 1 = positive |
| gain_update | input | 1 | Apply `gain_req` in normal operation |
| gain_req | input | GIDX_W | Requested gain state index |
| stage_gain | output | NSTAGE | Gain bit per stage |
| stage_trim | output | NSTAGE*TRIM_W | Offset trim codes, stage k at bits [TRIM_W*k +: TRIM_W] |
| input_short | output | 1 | Shorts the chain input during calibration |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-clock pulse at the end of a run |

## Verification
On every cycle, the assertions check the done pulse width, that a run only begins on a start request, that the input is shorted whenever the block is busy, that the gain pins always carry a thermometer pattern, and that idle pins change only after an accepted update. The bench alone can show the numbers. It checks the stored codes against a brute-force search of a behavioural chain model with per-stage offsets. It also checks the exact run length for two settling delays, clamping of out-of-range requests, and that requests made during a run are refused and the prior gain state comes back once the run ends.

// File: rtl/ocal_pkg.sv
// Package: shared types of the offset calibration sequencer.
// Assumes: nothing beyond a common clock domain.
package ocal_pkg;

    // Sequencer phases of a calibration run
    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_SETTLE  = 3'd1,
        SEQ_DECIDE  = 3'd2,
        SEQ_WRITE   = 3'd3,
        SEQ_RESTORE = 3'd4
    } seq_state_t;

endpackage

// File: rtl/ocal_seq.sv
// Module: ocal_seq
// Walks every gain state and, within each one, every stage from first to
// last, resolving each trim code MSB first against the output comparator.
// A finished state is written to the table; after the last state a restore
// strobe and a done pulse are issued.
// Assumes: cmp_hi is valid once the settle count has elapsed; NSTATE <= NSTAGE+1.
module ocal_seq
    import ocal_pkg::*;
#(
    parameter int NSTAGE   = 6,
    parameter int TRIM_W   = 3,
    parameter int NSTATE   = 7,
    parameter int SETTLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cal_start,
    input  logic [SETTLE_W-1:0]        settle_cycles,
    input  logic                       cmp_hi,
    output logic [NSTAGE-1:0]          cal_gain,
    output logic [NSTAGE*TRIM_W-1:0]   cal_trim,
    output logic                       busy,
    output logic                       short_en,
    output logic                       done,
    output logic                       wr_en,
    output logic [((NSTATE>1)?$clog2(NSTATE):1)-1:0] wr_idx,
    output logic                       restore
);

    localparam int ENTRY_W = NSTAGE * TRIM_W;
    localparam int SIDX_W  = (NSTATE > 1) ? $clog2(NSTATE) : 1;
    localparam int STG_W   = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;
    localparam int BIT_W   = (TRIM_W > 1) ? $clog2(TRIM_W) : 1;
    localparam int POS_W   = (ENTRY_W > 1) ? $clog2(ENTRY_W) : 1;
    localparam logic [TRIM_W-1:0]  MID     = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [ENTRY_W-1:0] MID_ALL = {NSTAGE{MID}};
    localparam logic [BIT_W-1:0]   MSB_POS = BIT_W'(TRIM_W - 1);

    seq_state_t           st;
    logic [SIDX_W-1:0]    sidx;
    logic [STG_W-1:0]     stg;
    logic [BIT_W-1:0]     bitp;
    logic [SETTLE_W-1:0]  cnt;
    logic [ENTRY_W-1:0]   trim_q;
    logic [ENTRY_W-1:0]   trim_dec;
    logic [POS_W-1:0]     pos;

    // Thermometer gain pattern for a state index
    function automatic logic [NSTAGE-1:0] therm(input logic [SIDX_W-1:0] i);
        logic [NSTAGE-1:0] r;
        for (int k = 0; k < NSTAGE; k++) begin
            r[k] = (k < int'(i));
        end
        return r;
    endfunction

    // Bit under test and the code after the comparator decision
    always_comb begin
        pos      = POS_W'(stg) * POS_W'(TRIM_W) + POS_W'(bitp);
        trim_dec = trim_q;
        if (cmp_hi) begin
            trim_dec = trim_dec & ~(ENTRY_W'(1) << pos);
        end
        if (bitp != '0) begin
            trim_dec = trim_dec | (ENTRY_W'(1) << (pos - POS_W'(1)));
        end
    end

    // Calibration sequencing through states, stages and bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SEQ_IDLE;
            sidx     <= '0;
            stg      <= '0;
            bitp     <= MSB_POS;
            cnt      <= '0;
            trim_q   <= MID_ALL;
            busy     <= 1'b0;
            short_en <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (cal_start) begin
                        busy     <= 1'b1;
                        short_en <= 1'b1;
                        sidx     <= '0;
                        stg      <= '0;
                        bitp     <= MSB_POS;
                        cnt      <= settle_cycles;
                        trim_q   <= MID_ALL;
                        st       <= SEQ_SETTLE;
                    end
                end
                SEQ_SETTLE: begin
                    if (cnt == '0) begin
                        st <= SEQ_DECIDE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_DECIDE: begin
                    trim_q <= trim_dec;
                    cnt    <= settle_cycles;
                    if (bitp != '0) begin
                        bitp <= bitp - 1'b1;
                        st   <= SEQ_SETTLE;
                    end else if (stg != STG_W'(NSTAGE - 1)) begin
                        stg  <= stg + 1'b1;
                        bitp <= MSB_POS;
                        st   <= SEQ_SETTLE;
                    end else begin
                        st <= SEQ_WRITE;
                    end
                end
                SEQ_WRITE: begin
                    if (sidx != SIDX_W'(NSTATE - 1)) begin
                        sidx   <= sidx + 1'b1;
                        stg    <= '0;
                        bitp   <= MSB_POS;
                        cnt    <= settle_cycles;
                        trim_q <= MID_ALL;
                        st     <= SEQ_SETTLE;
                    end else begin
                        st <= SEQ_RESTORE;
                    end
                end
                SEQ_RESTORE: begin
                    busy     <= 1'b0;
                    short_en <= 1'b0;
                    done     <= 1'b1;
                    st       <= SEQ_IDLE;
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    // Drive the chain and the table during a run
    always_comb begin
        cal_gain = therm(sidx);
        cal_trim = trim_q;
        wr_en    = (st == SEQ_WRITE);
        wr_idx   = sidx;
        restore  = (st == SEQ_RESTORE);
    end

    // R6
    // done_pulse_chk
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    // start_only_chk
    start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cal_start));

    // R6
    // done_after_busy_chk
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: rtl/ocal_store.sv
// Module: ocal_store
// Per-channel table of trim words, one word per gain state. Written by the
// sequencer, read combinationally by the apply logic.
// Assumes: rd_idx is already clamped below NSTATE.
module ocal_store #(
    parameter int NSTAGE = 6,
    parameter int TRIM_W = 3,
    parameter int NSTATE = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [((NSTATE>1)?$clog2(NSTATE):1)-1:0] wr_idx,
    input  logic [NSTAGE*TRIM_W-1:0]   wr_data,
    input  logic [((NSTATE>1)?$clog2(NSTATE):1)-1:0] rd_idx,
    output logic [NSTAGE*TRIM_W-1:0]   rd_data
);

    localparam int ENTRY_W = NSTAGE * TRIM_W;
    localparam logic [TRIM_W-1:0]  MID     = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [ENTRY_W-1:0] MID_ALL = {NSTAGE{MID}};

    logic [ENTRY_W-1:0] tbl [NSTATE];

    // One register word per gain state
    for (genvar g = 0; g < NSTATE; g++) begin : g_word
        // Load the word when the sequencer finishes its state
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[g] <= MID_ALL;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                tbl[g] <= wr_data;
            end
        end
    end

    // Read port with a safe default outside the table
    always_comb begin
        rd_data = MID_ALL;
        for (int g = 0; g < NSTATE; g++) begin
            if (int'(rd_idx) == g) begin
                rd_data = tbl[g];
            end
        end
    end

    // R3
    // write_in_range_chk
    write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NSTATE));

endmodule

// File: rtl/ocal_apply.sv
// Module: ocal_apply
// Normal-mode gain application: clamps the request, then loads gain bits
// and stored trims in the same cycle. Refuses requests while busy and
// reloads the held state when the sequencer signals restore.
// Assumes: rd_data is the table word for rd_idx in the same cycle.
module ocal_apply #(
    parameter int NSTAGE = 6,
    parameter int TRIM_W = 3,
    parameter int NSTATE = 7,
    parameter int GIDX_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       gain_update,
    input  logic [GIDX_W-1:0]          gain_req,
    input  logic                       busy,
    input  logic                       restore,
    input  logic [NSTAGE*TRIM_W-1:0]   rd_data,
    output logic [((NSTATE>1)?$clog2(NSTATE):1)-1:0] rd_idx,
    output logic [NSTAGE-1:0]          app_gain,
    output logic [NSTAGE*TRIM_W-1:0]   app_trim
);

    localparam int ENTRY_W = NSTAGE * TRIM_W;
    localparam int SIDX_W  = (NSTATE > 1) ? $clog2(NSTATE) : 1;
    localparam logic [TRIM_W-1:0]  MID     = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [ENTRY_W-1:0] MID_ALL = {NSTAGE{MID}};

    logic [SIDX_W-1:0] app_idx;
    logic [SIDX_W-1:0] req_idx;

    // Thermometer gain pattern for a state index
    function automatic logic [NSTAGE-1:0] therm(input logic [SIDX_W-1:0] i);
        logic [NSTAGE-1:0] r;
        for (int k = 0; k < NSTAGE; k++) begin
            r[k] = (k < int'(i));
        end
        return r;
    endfunction

    // Clamp the request to the last stored state and pick the read index
    always_comb begin
        if (32'(gain_req) > NSTATE - 1) begin
            req_idx = SIDX_W'(NSTATE - 1);
        end else begin
            req_idx = SIDX_W'(gain_req);
        end
        rd_idx = restore ? app_idx : req_idx;
    end

    // Load gain and trims together on an accepted update or a restore
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_idx  <= '0;
            app_gain <= '0;
            app_trim <= MID_ALL;
        end else if (restore) begin
            app_gain <= therm(app_idx);
            app_trim <= rd_data;
        end else if (gain_update && !busy) begin
            app_idx  <= req_idx;
            app_gain <= therm(req_idx);
            app_trim <= rd_data;
        end
    end

    // R8
    // held_idx_range_chk
    held_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(app_idx) < NSTATE);

endmodule

// File: rtl/ocal_seq_top.sv
// Module: ocal_seq_top
// Offset calibration sequencer for a cascaded amplifier chain: sequencer,
// per-state code table and normal-mode apply logic. During a run the
// sequencer owns the stage pins; otherwise the applied registers do.
// Assumes: one comparator at the chain output, sampled synchronously.
module ocal_seq_top #(
    parameter int NSTAGE   = 6,
    parameter int TRIM_W   = 3,
    parameter int NSTATE   = 7,
    parameter int GIDX_W   = 3,
    parameter int SETTLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cal_start,
    input  logic [SETTLE_W-1:0]        settle_cycles,
    input  logic                       cmp_hi,
    input  logic                       gain_update,
    input  logic [GIDX_W-1:0]          gain_req,
    output logic [NSTAGE-1:0]          stage_gain,
    output logic [NSTAGE*TRIM_W-1:0]   stage_trim,
    output logic                       input_short,
    output logic                       cal_busy,
    output logic                       cal_done
);

    localparam int ENTRY_W = NSTAGE * TRIM_W;
    localparam int SIDX_W  = (NSTATE > 1) ? $clog2(NSTATE) : 1;

    logic [NSTAGE-1:0]  cal_gain;
    logic [ENTRY_W-1:0] cal_trim;
    logic               wr_en;
    logic [SIDX_W-1:0]  wr_idx;
    logic               restore;
    logic [SIDX_W-1:0]  rd_idx;
    logic [ENTRY_W-1:0] rd_data;
    logic [NSTAGE-1:0]  app_gain;
    logic [ENTRY_W-1:0] app_trim;
    logic               past_ok;

    ocal_seq #(
        .NSTAGE(NSTAGE), .TRIM_W(TRIM_W), .NSTATE(NSTATE), .SETTLE_W(SETTLE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .settle_cycles(settle_cycles), .cmp_hi(cmp_hi),
        .cal_gain(cal_gain), .cal_trim(cal_trim),
        .busy(cal_busy), .short_en(input_short), .done(cal_done),
        .wr_en(wr_en), .wr_idx(wr_idx), .restore(restore)
    );

    ocal_store #(
        .NSTAGE(NSTAGE), .TRIM_W(TRIM_W), .NSTATE(NSTATE)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(cal_trim), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    ocal_apply #(
        .NSTAGE(NSTAGE), .TRIM_W(TRIM_W), .NSTATE(NSTATE), .GIDX_W(GIDX_W)
    ) u_apply (
        .clk(clk), .rst_n(rst_n), .gain_update(gain_update),
        .gain_req(gain_req), .busy(cal_busy), .restore(restore),
        .rd_data(rd_data), .rd_idx(rd_idx),
        .app_gain(app_gain), .app_trim(app_trim)
    );

    // Stage pins follow the sequencer during a run, the applied state otherwise
    always_comb begin
        stage_gain = cal_busy ? cal_gain : app_gain;
        stage_trim = cal_busy ? cal_trim : app_trim;
    end

    // Marks cycles whose history lies after reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2
    // short_when_busy_chk
    short_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> input_short);

    // R4
    // gain_therm_chk
    gain_therm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_gain & (stage_gain + 1'b1)) == '0));

    // R10
    // idle_hold_chk
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !cal_busy && !$past(cal_busy) && !$past(gain_update))
        |-> ($stable(stage_gain) && $stable(stage_trim)));

endmodule

// File: tb/ocal_seq_top_test.sv
// Bench: behavioural amplifier chain with per-stage offsets drives the
// comparator; expected codes come from a brute-force search per stage.
module ocal_seq_top_test;

    localparam int NS = 6;
    localparam int TW = 3;
    localparam int NG = 7;
    localparam logic [17:0] MID_ALL = {NS{3'b100}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0;
    logic [7:0]  settle_cycles = 8'd0;
    logic        cmp_hi;
    logic        gain_update = 1'b0;
    logic [2:0]  gain_req = 3'd0;
    logic [5:0]  stage_gain;
    logic [17:0] stage_trim;
    logic        input_short;
    logic        cal_busy;
    logic        cal_done;

    int          n_chk = 0;
    int          n_bad = 0;
    int          off [NS];
    logic [17:0] exp_tbl [NG];

    ocal_seq_top uut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .settle_cycles(settle_cycles), .cmp_hi(cmp_hi),
        .gain_update(gain_update), .gain_req(gain_req),
        .stage_gain(stage_gain), .stage_trim(stage_trim),
        .input_short(input_short), .cal_busy(cal_busy), .cal_done(cal_done)
    );

    always #5 clk = ~clk;

    function automatic logic [5:0] therm(input int i);
        logic [5:0] r;
        for (int k = 0; k < NS; k++) r[k] = (k < i);
        return r;
    endfunction

    // Chain output: each stage adds offset plus trim step, then amplifies
    function automatic int chain_v(input logic [17:0] t, input logic [5:0] g);
        int acc = 0;
        for (int k = 0; k < NS; k++) begin
            acc = (acc + off[k] + 2 * int'(t[k*TW +: TW]) - 7) * (g[k] ? 2 : 1);
        end
        return acc;
    endfunction

    always_comb cmp_hi = (chain_v(stage_trim, stage_gain) > 0);

    // Largest code per stage with non-positive output, stages in order
    task automatic build_expected();
        for (int g = 0; g < NG; g++) begin
            logic [17:0] t = MID_ALL;
            for (int s = 0; s < NS; s++) begin
                int best = 0;
                for (int c = 0; c < 8; c++) begin
                    t[s*TW +: TW] = 3'(c);
                    if (chain_v(t, therm(g)) <= 0) best = c;
                end
                t[s*TW +: TW] = 3'(best);
            end
            exp_tbl[g] = t;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic apply_gain(input int r);
        @(negedge clk);
        gain_req = 3'(r);
        gain_update = 1'b1;
        @(negedge clk);
        gain_update = 1'b0;
    endtask

    // Apply every request and compare gain and trims with the model
    task automatic sweep();
        for (int r = 0; r < 8; r++) begin
            int e = (r > NG - 1) ? NG - 1 : r;
            apply_gain(r);
            if (r > NG - 1) begin
                check("R8 clamp gain", 32'(stage_gain), 32'(therm(e)));
                check("R8 clamp trim", 32'(stage_trim), 32'(exp_tbl[e]));
            end else begin
                check("R4 gain pattern", 32'(stage_gain), 32'(therm(e)));
                check("R3 R7 stored trims", 32'(stage_trim), 32'(exp_tbl[e]));
            end
        end
        repeat (3) @(negedge clk);
        check("R10 hold gain", 32'(stage_gain), 32'(therm(NG - 1)));
        check("R10 hold trim", 32'(stage_trim), 32'(exp_tbl[NG - 1]));
    endtask

    // One run with a start retry and a refused gain request inside it
    task automatic run_cal(input int s, input int hold_idx);
        int len = 0;
        int exp_len = NG * (NS * TW * (s + 2) + 1) + 1;
        @(negedge clk);
        settle_cycles = 8'(s);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        check("R2 busy rises", 32'(cal_busy), 32'd1);
        check("R2 short rises", 32'(input_short), 32'd1);
        while (cal_busy && len < 5000) begin
            len++;
            if (!input_short) check("R2 short held", 32'(input_short), 32'd1);
            cal_start   = (len == 10);
            gain_update = (len == 20);
            gain_req    = 3'd5;
            @(negedge clk);
        end
        cal_start = 1'b0;
        gain_update = 1'b0;
        check("R5 R2 run length", 32'(len), 32'(exp_len));
        check("R6 done at end", 32'(cal_done), 32'd1);
        check("R9 restored gain", 32'(stage_gain), 32'(therm(hold_idx)));
        check("R9 restored trim", 32'(stage_trim), 32'(exp_tbl[hold_idx]));
        @(negedge clk);
        check("R6 done one cycle", 32'(cal_done), 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 gain", 32'(stage_gain), 32'd0);
        check("R1 trim", 32'(stage_trim), 32'(MID_ALL));
        check("R1 busy", 32'(cal_busy), 32'd0);
        check("R1 short", 32'(input_short), 32'd0);
        check("R1 done", 32'(cal_done), 32'd0);
        apply_gain(2);
        check("R1 R7 table midscale", 32'(stage_trim), 32'(MID_ALL));
        check("R7 gain", 32'(stage_gain), 32'(therm(2)));

        off = '{2, -4, 7, -1, 0, -6};
        build_expected();
        run_cal(2, 2);
        sweep();

        off = '{-3, 5, -8, 3, -2, 4};
        build_expected();
        apply_gain(4);
        run_cal(0, 4);
        sweep();

        finish_up();
    end

endmodule